// File: doc/BRIEF.md
# Reverse-Order DES Subkey Generator

This block supplies the 48-bit round subkeys of DES one at a time, computed on demand, so the cipher datapath never reads a register file of sixteen precomputed keys. A 64-bit key is captured on a load strobe. Its 56 key bits are selected by the PC-1 permutation and split into two 28-bit halves, which are the only state kept. Each round's subkey is formed combinationally from the current halves through the PC-2 permutation.

A mode bit is sampled together with the key. In encryption mode the subkeys appear in the order K1, K2, ..., K16, with the halves rotated left between rounds. In decryption mode they appear in the order K16, K15, ..., K1. This reverse order comes from rotating the halves right, starting from their unrotated PC-1 value. The cipher round logic raises an advance strobe once per round. The block then moves to the next subkey and increments a 4-bit round index that the datapath can use for sequencing.

Top module: `des_rev_subkey_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the halves and the round index clear. After reset `round_o` is 0 and `subkey_o` is 0.
- R2: The 56 key bits are taken by PC-1 from `key_i`, where `key_i[63]` is key bit 1. The eight parity bits `key_i[56]`, `key_i[48]`, ..., `key_i[0]` have no effect on any subkey.
- R3: Suppose a load with `decrypt_i`=0 is followed by N advances (N from 0 to 15). Then `subkey_o` equals the standard DES subkey K(N+1), and `subkey_o[47]` is subkey bit 1. For key 0x133457799BBCDFF1, K1 is 0x1B02EFFC7072.
- R4: Suppose a load with `decrypt_i`=1 is followed by N advances (N from 0 to 15). Then `subkey_o` equals K(16−N). K16 comes from the unrotated PC-1 halves. For key 0x133457799BBCDFF1, K16 is 0xCB3D8B0E17F5.
- R5: Each advance without a load increments `round_o` by one, modulo 16. An advance from index 15 returns to index 0 and to the first subkey of the current mode (K1 when encrypting, K16 when decrypting).
- R6: A load sets `round_o` to 0 and reloads the halves from the new key. A load takes priority over an advance in the same cycle.
- R7: The mode is captured only at a load. Changing `decrypt_i` between loads does not alter the subkey sequence.
- R8: In a cycle with neither load nor advance, `subkey_o` and `round_o` hold their values.
- R9: `subkey_o` and `round_o` reflect a load or an advance from the clock edge that samples it, with no further latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Capture `key_i` and `decrypt_i`, restart at index 0 |
| decrypt_i | input | 1 | 1 = reverse (decryption) subkey order, sampled at load |
| key_i | input | 64 | DES key including parity bits, bit 1 at MSB |
| advance_i | input | 1 | Step to the next round's subkey |
| subkey_o | output | 48 | Current round subkey, bit 1 at MSB |
| round_o | output | 4 | Current round index, 0 to 15 |

## Verification
Both outputs are registered state, or PC-2 wiring from registered state, so every result is due right after the clock edge that samples the load or advance strobe. The bench drives strobes on the falling edge, holds them across one rising edge and compares on the next falling edge. Every subkey of both orders is compared against a left-shift model of the standard schedule, and two subkeys of a well-known key are compared against fixed constants. Idle cycles, parity-bit flips, a mode toggle mid-sequence, a reload mid-sequence and a simultaneous load and advance are each checked one half-cycle after their edge.

// File: rtl/des_ks_pkg.sv
// Package: constants, permutation tables and rotation helpers for the
// DES subkey generator. Table entries use DES numbering (bit 1 = MSB).
package des_ks_pkg;

    localparam int KEY_W   = 64;
    localparam int HALF_W  = 28;
    localparam int CD_W    = 2 * HALF_W;
    localparam int SUBK_W  = 48;
    localparam int ROUNDS  = 16;
    localparam int IDX_W   = $clog2(ROUNDS);

    // Key-bit selection (PC-1): output bit i+1 takes key bit PC1_TAB[i].
    localparam int PC1_TAB [CD_W] = '{
        57, 49, 41, 33, 25, 17,  9,
         1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27,
        19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,
         7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29,
        21, 13,  5, 28, 20, 12,  4
    };

    // Subkey compression (PC-2): output bit i+1 takes C||D bit PC2_TAB[i].
    localparam int PC2_TAB [SUBK_W] = '{
        14, 17, 11, 24,  1,  5,
         3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8,
        16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55,
        30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53,
        46, 42, 50, 36, 29, 32
    };

    // True when the left shift before zero-based round r is two bits.
    function automatic logic shift_is_double(input logic [IDX_W-1:0] r);
        return !(r == 4'd0 || r == 4'd1 || r == 4'd8 || r == 4'd15);
    endfunction

    // Rotate one half by one or two positions, left or right (MSB = bit 1).
    function automatic logic [HALF_W-1:0] rot_half(input logic [HALF_W-1:0] x,
                                                   input logic two,
                                                   input logic left);
        if (left)
            return two ? {x[HALF_W-3:0], x[HALF_W-1:HALF_W-2]}
                       : {x[HALF_W-2:0], x[HALF_W-1]};
        else
            return two ? {x[1:0], x[HALF_W-1:2]}
                       : {x[0], x[HALF_W-1:1]};
    endfunction

endpackage

// File: rtl/des_ks_pc1.sv
// Module: des_ks_pc1
// Pure wiring that selects the 56 key bits from a 64-bit key (PC-1).
// Assumes key bit 1 sits at the MSB; parity bits are simply not routed.
module des_ks_pc1
    import des_ks_pkg::*;
(
    input  logic [KEY_W-1:0] key_i,
    output logic [CD_W-1:0]  cd_o
);
    // One wire per selected bit, placed by the PC-1 table.
    for (genvar g = 0; g < CD_W; g++) begin : g_sel
        assign cd_o[CD_W-1-g] = key_i[KEY_W-PC1_TAB[g]];
    end
endmodule

// File: rtl/des_ks_pc2.sv
// Module: des_ks_pc2
// Pure wiring that compresses the 56-bit C||D state into a 48-bit
// subkey (PC-2). Assumes C occupies the upper 28 bits, bit 1 at MSB.
module des_ks_pc2
    import des_ks_pkg::*;
(
    input  logic [CD_W-1:0]   cd_i,
    output logic [SUBK_W-1:0] subkey_o
);
    // One wire per subkey bit, placed by the PC-2 table.
    for (genvar g = 0; g < SUBK_W; g++) begin : g_sel
        assign subkey_o[SUBK_W-1-g] = cd_i[CD_W-PC2_TAB[g]];
    end
endmodule

// File: rtl/des_ks_halves.sv
// Module: des_ks_halves
// Holds the two 28-bit halves, the round index and the captured mode.
// A load installs the halves ready for the first subkey of the chosen
// order; each advance rotates them left (encrypt) or right (decrypt).
// Assumes load has priority over advance; reset is synchronous, active low.
module des_ks_halves
    import des_ks_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              decrypt_i,
    input  logic              advance_i,
    input  logic [CD_W-1:0]   pc1_cd_i,
    output logic [CD_W-1:0]   cd_o,
    output logic [IDX_W-1:0]  round_o
);
    logic [HALF_W-1:0] c_q, d_q;
    logic [IDX_W-1:0]  round_q;
    logic              dec_q;
    logic              step_two;
    logic [IDX_W-1:0]  shift_round;

    // Choose the shift size: encrypt looks ahead one round, decrypt undoes
    // the shift of the round just served.
    always_comb begin
        shift_round = dec_q ? ~round_q : round_q + 4'd1;
        step_two    = shift_is_double(shift_round);
    end

    // Load, rotate or hold the key state and the round index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q     <= '0;
            d_q     <= '0;
            round_q <= '0;
            dec_q   <= 1'b0;
        end else if (load_i) begin
            dec_q   <= decrypt_i;
            round_q <= '0;
            if (decrypt_i) begin
                c_q <= pc1_cd_i[CD_W-1:HALF_W];
                d_q <= pc1_cd_i[HALF_W-1:0];
            end else begin
                c_q <= rot_half(pc1_cd_i[CD_W-1:HALF_W], 1'b0, 1'b1);
                d_q <= rot_half(pc1_cd_i[HALF_W-1:0], 1'b0, 1'b1);
            end
        end else if (advance_i) begin
            round_q <= round_q + 4'd1;
            c_q     <= rot_half(c_q, step_two, !dec_q);
            d_q     <= rot_half(d_q, step_two, !dec_q);
        end
    end

    assign cd_o    = {c_q, d_q};
    assign round_o = round_q;

    // R5: the index steps by one on each advance, wrapping at 16.
    a_r5_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !load_i) |=> (round_q == $past(round_q) + 4'd1));

    // R6: a load always restarts the index at zero.
    a_r6_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (round_q == '0));

    // R8: an idle cycle leaves halves and index untouched.
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !advance_i) |=> ($stable(c_q) && $stable(d_q) && $stable(round_q)));

    // R3: an advance is a pure rotation, so each half keeps its bit weight.
    a_r3_rotation_weight: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !load_i) |=>
        ($countones(c_q) == $countones($past(c_q)) &&
         $countones(d_q) == $countones($past(d_q))));

    // R7: the captured mode changes only on a load.
    a_r7_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(dec_q));

endmodule

// File: rtl/des_rev_subkey_gen.sv
// Module: des_rev_subkey_gen (top)
// On-the-fly DES subkey source for either round order. Wires PC-1 into
// the half-state registers and PC-2 out of them; the subkey is purely
// combinational from the registered halves, so there is no stored table.
// Assumes the datapath raises advance_i once per round after a load.
module des_rev_subkey_gen
    import des_ks_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              decrypt_i,
    input  logic [KEY_W-1:0]  key_i,
    input  logic              advance_i,
    output logic [SUBK_W-1:0] subkey_o,
    output logic [IDX_W-1:0]  round_o
);
    logic [CD_W-1:0] pc1_cd;
    logic [CD_W-1:0] cur_cd;

    des_ks_pc1 u_pc1 (
        .key_i (key_i),
        .cd_o  (pc1_cd)
    );

    des_ks_halves u_halves (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .decrypt_i (decrypt_i),
        .advance_i (advance_i),
        .pc1_cd_i  (pc1_cd),
        .cd_o      (cur_cd),
        .round_o   (round_o)
    );

    des_ks_pc2 u_pc2 (
        .cd_i     (cur_cd),
        .subkey_o (subkey_o)
    );

    // R1: one cycle out of reset the index reads zero.
    a_r1_reset_index: assert property (@(posedge clk)
        !rst_n |=> (round_o == '0));

endmodule

// File: tb/des_rev_subkey_gen_tb.sv
// Bench for des_rev_subkey_gen: a vector table of keys and modes walked by
// one loop against a left-shift model, then directed corner cases.
module des_rev_subkey_gen_tb;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic        decrypt_i = 1'b0;
    logic [63:0] key_i = '0;
    logic        advance_i = 1'b0;
    logic [47:0] subkey_o;
    logic [3:0]  round_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    des_rev_subkey_gen u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .decrypt_i(decrypt_i),
        .key_i(key_i), .advance_i(advance_i), .subkey_o(subkey_o), .round_o(round_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference tables of the standard schedule.
    localparam int M_PC1 [56] = '{57,49,41,33,25,17,9,1,58,50,42,34,26,18,
        10,2,59,51,43,35,27,19,11,3,60,52,44,36,63,55,47,39,31,23,15,
        7,62,54,46,38,30,22,14,6,61,53,45,37,29,21,13,5,28,20,12,4};
    localparam int M_PC2 [48] = '{14,17,11,24,1,5,3,28,15,6,21,10,
        23,19,12,4,26,8,16,7,27,20,13,2,41,52,31,37,47,55,
        30,40,51,45,33,48,44,49,39,56,34,53,46,42,50,36,29,32};

    // Standard left-shift model: subkey Kn for n in 1..16.
    function automatic logic [47:0] ref_key(input logic [63:0] k, input int n);
        logic [55:0] cd;
        logic [27:0] c, d;
        logic [47:0] r;
        for (int i = 0; i < 56; i++) cd[55-i] = k[64-M_PC1[i]];
        c = cd[55:28];
        d = cd[27:0];
        for (int j = 1; j <= n; j++) begin
            int amt = (j == 1 || j == 2 || j == 9 || j == 16) ? 1 : 2;
            for (int s = 0; s < amt; s++) begin
                c = {c[26:0], c[27]};
                d = {d[26:0], d[27]};
            end
        end
        cd = {c, d};
        for (int i = 0; i < 48; i++) r[47-i] = cd[56-M_PC2[i]];
        return r;
    endfunction

    function automatic logic [47:0] expect_at(input logic [63:0] k, input bit dec, input int idx);
        return dec ? ref_key(k, 16 - idx) : ref_key(k, idx + 1);
    endfunction

    task automatic check48(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: subkey actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: round actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Strobes are driven on the falling edge and results read one edge later.
    task automatic do_load(input logic [63:0] k, input bit dec);
        @(negedge clk);
        key_i = k; decrypt_i = dec; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic do_advance();
        @(negedge clk);
        advance_i = 1'b1;
        @(negedge clk);
        advance_i = 1'b0;
    endtask

    // Vector table: {key, decrypt}.
    localparam logic [64:0] VEC [6] = '{
        {64'h133457799BBCDFF1, 1'b0},
        {64'h133457799BBCDFF1, 1'b1},
        {64'h0123456789ABCDEF, 1'b0},
        {64'hFEDCBA9876543210, 1'b1},
        {64'h8000000000000002, 1'b1},
        {64'hA5C3F00F1E2D4B69, 1'b0}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        check4("R1", round_o, 4'd0);
        check48("R1", subkey_o, 48'h0);
        rst_n = 1'b1;

        // R3/R4/R9: every subkey of each vector, one edge after each strobe.
        foreach (VEC[v]) begin
            logic [63:0] k = VEC[v][64:1];
            bit dec = VEC[v][0];
            do_load(k, dec);
            for (int idx = 0; idx < 16; idx++) begin
                if (idx != 0) do_advance();
                check4("R5", round_o, idx[3:0]);
                check48(dec ? "R4" : "R3", subkey_o, expect_at(k, dec, idx));
            end
            // R5: wrap back to the first subkey of the mode.
            do_advance();
            check4("R5", round_o, 4'd0);
            check48("R5", subkey_o, expect_at(k, dec, 0));
        end

        // R3/R4: fixed known answers; MSB is subkey bit 1.
        do_load(64'h133457799BBCDFF1, 1'b0);
        check48("R3", subkey_o, 48'h1B02EFFC7072);
        do_load(64'h133457799BBCDFF1, 1'b1);
        check48("R4", subkey_o, 48'hCB3D8B0E17F5);

        // R2: flipping all parity bits changes nothing.
        do_load(64'h133457799BBCDFF1 ^ 64'h0101010101010101, 1'b1);
        for (int idx = 0; idx < 16; idx++) begin
            if (idx != 0) do_advance();
            check48("R2", subkey_o, expect_at(64'h133457799BBCDFF1, 1'b1, idx));
        end

        // R8: idle cycles hold subkey and index.
        do_load(64'h0123456789ABCDEF, 1'b0);
        do_advance(); do_advance();
        repeat (4) @(negedge clk);
        check4("R8", round_o, 4'd2);
        check48("R8", subkey_o, expect_at(64'h0123456789ABCDEF, 1'b0, 2));

        // R7: toggling the mode between loads has no effect.
        decrypt_i = 1'b1;
        do_advance(); do_advance();
        check4("R7", round_o, 4'd4);
        check48("R7", subkey_o, expect_at(64'h0123456789ABCDEF, 1'b0, 4));

        // R6: a mid-sequence reload restarts at index 0 with the new key.
        do_load(64'hFEDCBA9876543210, 1'b1);
        check4("R6", round_o, 4'd0);
        check48("R6", subkey_o, expect_at(64'hFEDCBA9876543210, 1'b1, 0));

        // R6: load wins over a simultaneous advance.
        do_advance(); do_advance();
        @(negedge clk);
        key_i = 64'hA5C3F00F1E2D4B69; decrypt_i = 1'b0; load_i = 1'b1; advance_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0; advance_i = 1'b0;
        check4("R6", round_o, 4'd0);
        check48("R6", subkey_o, expect_at(64'hA5C3F00F1E2D4B69, 1'b0, 0));

        // R1: reset mid-sequence clears the state again.
        do_advance();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check4("R1", round_o, 4'd0);
        check48("R1", subkey_o, 48'h0);
        rst_n = 1'b1;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule